// File: doc/BRIEF.md
# PC Card Attribute Configuration Registers

This block holds the four byte-wide configuration registers that a PC Card host reaches in attribute space: the option register, the configuration/status register, the pin replacement register and the socket/copy register. The host writes and reads them with single-cycle strobes and an attribute byte address. Reads return data one clock after the strobe. The register contents drive the card's mapping index, its interrupt mode, a sticky soft-reset request, a power-down request, the 8-bit I/O flag and the drive number. From its live ready input and its interrupt inputs the block also builds the status bits the host reads back and the active-low status-change pin.

A small power-transition state machine tracks each requested change of the power-down bit. It has four states: PW_AWAKE, PW_GOING_DOWN, PW_ASLEEP and PW_WAKING. Its transitions are:
- PW_AWAKE to PW_GOING_DOWN, when the power-down bit is set.
- PW_GOING_DOWN to PW_ASLEEP, when the core reports sleep.
- PW_GOING_DOWN to PW_WAKING, when the power-down bit is cleared before sleep is reached.
- PW_ASLEEP to PW_WAKING, when the power-down bit is cleared.
- PW_WAKING to PW_AWAKE, when the core reports it is awake.
- PW_WAKING to PW_GOING_DOWN, when the power-down bit is set again.

While the machine is in PW_GOING_DOWN or PW_WAKING, the ready bit the host sees reads busy. A change of that visible ready bit sets a sticky change flag. When enabled, that flag drives the status-change pin low in I/O mode.

Top module: `pccfg_regs`

## Requirements
- R1: After hard reset the registers read 00h (option, base+0), 00h (status, base+2), 0Ch (pin replacement, base+4, with the ready input low) and 00h (socket, base+6). After reset the mapping index is 0, the soft-reset and power-down requests are 0, and the status-change pin is high. Read data appears on the clock after the read strobe.
- R2: A write to the option register stores bits 5..0 as the mapping index and bit 6 as the interrupt mode (1 = level, 0 = pulse). Both read back at the same positions.
- R3: Option bit 7 is a soft-reset request. It stays set until the host writes it 0 or a hard reset occurs. Any option write with bit 7 set stores index 0, so while the request is set the index reads 0.
- R4: In the status register, bit 6 (status-change enable), bit 5 (8-bit I/O) and bit 2 (power-down) are host-writable. Bits 4, 3 and 0 always read 0.
- R5: Status bit 1 reads as the interrupt-pending input AND the interrupt-enable input.
- R6: A write that changes the power-down bit makes the visible ready bit (pin replacement bit 1) read 0 from the next clock on. It stays 0 until the power-state input matches the requested state.
- R7: Pin replacement bit 1 reads the live ready input gated by R6, and bits 3..2 read 1. Bit 5 (change flag) sets one clock after the visible ready bit changes.
- R8: A pin replacement write with bit 1 = 1 loads bit 5 into the change flag. With bit 1 = 0, the change flag is left unchanged. If a ready change happens in the same clock, setting wins.
- R9: Status bit 7 reads the change flag and cannot be written.
- R10: The status-change pin is low exactly when the change flag is set, status bit 6 is set and the mapping index is non-zero (I/O mode).
- R11: Socket register bit 4 holds the drive number written by the host. Its other bits read 0.
- R12: Writes to odd attribute addresses, and to even addresses outside the four registers, change nothing. Reads from them return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| acc_addr | input | ADDR_W | Attribute byte address |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_data | output | 8 | Read byte, valid the clock after rd_en |
| ready_in | input | 1 | Live card ready (1 = ready) |
| pwr_asleep | input | 1 | Core reports it has reached sleep |
| irq_pend | input | 1 | Internal interrupt request pending |
| irq_en | input | 1 | Interrupt enable from device control |
| map_index | output | 6 | Mapping index (0 = memory mode) |
| level_irq | output | 1 | 1 = level interrupts, 0 = pulse |
| soft_rst_req | output | 1 | Sticky soft-reset request |
| pwr_down_req | output | 1 | Requested power-down |
| io8_flag | output | 1 | Host supports only 8-bit I/O |
| drive_num | output | 1 | Drive number |
| stschg_n | output | 1 | Active-low status-change pin |

## Verification
The main function is exercised with three kinds of input pattern. Register writes followed by read-back separate the writable bits from the fixed ones. Ready-input edges, with and without a pending power-state change, show that the change flag follows the visible ready bit and not the raw pin. Masked and unmasked pin replacement writes show that the write mask works. The status-change pin is then stepped through each of its three enabling conditions one at a time, to confirm that each condition alone can release it. Odd and unmapped addresses are written between reads of the real registers, to show that nothing is disturbed.

// File: rtl/pccfg_pkg.sv
package pccfg_pkg;
    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        PW_AWAKE,
        PW_GOING_DOWN,
        PW_ASLEEP,
        PW_WAKING
    } pw_state_t;

    // bit positions decoded by the host
    localparam int B_SRST   = 7;
    localparam int B_LEVEL  = 6;
    localparam int B_CHG    = 7;
    localparam int B_SIGEN  = 6;
    localparam int B_IO8    = 5;
    localparam int B_PWD    = 2;
    localparam int B_INTR   = 1;
    localparam int B_CFLAG  = 5;
    localparam int B_RDY    = 1;
    localparam int B_DRV    = 4;
endpackage

// File: rtl/pccfg_pwr_fsm.sv
module pccfg_pwr_fsm
    import pccfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwd_nxt,
    input  logic pwr_asleep,
    output logic busy
);
    pw_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_AWAKE:      if (pwd_nxt) state_d = PW_GOING_DOWN;
            PW_GOING_DOWN: if (!pwd_nxt) state_d = PW_WAKING;
                           else if (pwr_asleep) state_d = PW_ASLEEP;
            PW_ASLEEP:     if (!pwd_nxt) state_d = PW_WAKING;
            PW_WAKING:     if (pwd_nxt) state_d = PW_GOING_DOWN;
                           else if (!pwr_asleep) state_d = PW_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PW_GOING_DOWN, PW_WAKING: busy = 1'b1;
            default:                  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pccfg_chg_det.sv
module pccfg_chg_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_pin,
    input  logic busy,
    input  logic host_wr,
    input  logic host_mask,
    input  logic host_val,
    output logic rrdy_now,
    output logic rrdy_q,
    output logic crdy_q
);
    assign rrdy_now = ready_pin & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rrdy_q <= 1'b0;
            crdy_q <= 1'b0;
        end else begin
            rrdy_q <= rrdy_now;
            if (rrdy_now != rrdy_q)
                crdy_q <= 1'b1;
            else if (host_wr && host_mask)
                crdy_q <= host_val;
        end
    end
endmodule

// File: rtl/pccfg_regs.sv
module pccfg_regs
    import pccfg_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BASE_ADDR = 'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    input  logic              ready_in,
    input  logic              pwr_asleep,
    input  logic              irq_pend,
    input  logic              irq_en,
    output logic [IDX_W-1:0]  map_index,
    output logic              level_irq,
    output logic              soft_rst_req,
    output logic              pwr_down_req,
    output logic              io8_flag,
    output logic              drive_num,
    output logic              stschg_n
);
    localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + 2);
    localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(BASE_ADDR + 4);
    localparam logic [ADDR_W-1:0] A_SOCK = ADDR_W'(BASE_ADDR + 6);

    logic hit_opt, hit_stat, hit_pin, hit_sock;
    logic sigen_q, pwd_nxt, pwr_busy;
    logic rrdy_now, rrdy_q, crdy_q;
    logic intr;
    logic [7:0] rd_mux;

    assign hit_opt  = (acc_addr == A_OPT);
    assign hit_stat = (acc_addr == A_STAT);
    assign hit_pin  = (acc_addr == A_PIN);
    assign hit_sock = (acc_addr == A_SOCK);

    assign pwd_nxt = (wr_en && hit_stat) ? wr_data[B_PWD] : pwr_down_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_index    <= '0;
            level_irq    <= 1'b0;
            soft_rst_req <= 1'b0;
            sigen_q      <= 1'b0;
            io8_flag     <= 1'b0;
            pwr_down_req <= 1'b0;
            drive_num    <= 1'b0;
        end else if (wr_en) begin
            if (hit_opt) begin
                soft_rst_req <= wr_data[B_SRST];
                level_irq    <= wr_data[B_LEVEL];
                map_index    <= wr_data[B_SRST] ? '0 : wr_data[IDX_W-1:0];
            end
            if (hit_stat) begin
                sigen_q      <= wr_data[B_SIGEN];
                io8_flag     <= wr_data[B_IO8];
                pwr_down_req <= wr_data[B_PWD];
            end
            if (hit_sock) drive_num <= wr_data[B_DRV];
        end
    end

    pccfg_pwr_fsm u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwd_nxt    (pwd_nxt),
        .pwr_asleep (pwr_asleep),
        .busy       (pwr_busy)
    );

    pccfg_chg_det u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_pin (ready_in),
        .busy      (pwr_busy),
        .host_wr   (wr_en && hit_pin),
        .host_mask (wr_data[B_RDY]),
        .host_val  (wr_data[B_CFLAG]),
        .rrdy_now  (rrdy_now),
        .rrdy_q    (rrdy_q),
        .crdy_q    (crdy_q)
    );

    assign intr = irq_pend & irq_en;

    always_comb begin
        rd_mux = 8'h00;
        if (hit_opt) begin
            rd_mux[B_SRST]      = soft_rst_req;
            rd_mux[B_LEVEL]     = level_irq;
            rd_mux[IDX_W-1:0]   = map_index;
        end else if (hit_stat) begin
            rd_mux[B_CHG]   = crdy_q;
            rd_mux[B_SIGEN] = sigen_q;
            rd_mux[B_IO8]   = io8_flag;
            rd_mux[B_PWD]   = pwr_down_req;
            rd_mux[B_INTR]  = intr;
        end else if (hit_pin) begin
            rd_mux[B_CFLAG] = crdy_q;
            rd_mux[3:2]     = 2'b11;
            rd_mux[B_RDY]   = rrdy_now;
        end else if (hit_sock) begin
            rd_mux[B_DRV]   = drive_num;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign stschg_n = ~(crdy_q & sigen_q & (map_index != '0));
endmodule

// File: rtl/pccfg_chk.sv
module pccfg_chk #(
    parameter int ADDR_W    = 10,
    parameter int BASE_ADDR = 'h200
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [5:0]        map_index,
    input logic              soft_rst_req,
    input logic              pwr_down_req,
    input logic              drive_num,
    input logic              stschg_n,
    input logic              busy,
    input logic              rrdy_now,
    input logic              rrdy_q,
    input logic              crdy_q
);
    localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + 2);

    a_r3_sreset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req && !(wr_en && acc_addr == A_OPT) |=> soft_rst_req);

    a_r3_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> map_index == '0);

    a_r6_busy_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_addr == A_STAT && wr_data[2] != pwr_down_req |=> busy);

    a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rrdy_now != rrdy_q |=> crdy_q);

    a_r10_pin_io_only: assert property (@(posedge clk) disable iff (!rst_n)
        !stschg_n |-> map_index != '0 && crdy_q);

    a_r12_odd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && acc_addr[0] |=> $stable(map_index) && $stable(drive_num)
                                 && $stable(pwr_down_req) && $stable(soft_rst_req));
endmodule

bind pccfg_regs pccfg_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_addr     (acc_addr),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .map_index    (map_index),
    .soft_rst_req (soft_rst_req),
    .pwr_down_req (pwr_down_req),
    .drive_num    (drive_num),
    .stschg_n     (stschg_n),
    .busy         (pwr_busy),
    .rrdy_now     (rrdy_now),
    .rrdy_q       (rrdy_q),
    .crdy_q       (crdy_q)
);

// File: tb/tb_pccfg_regs.sv
module tb_pccfg_regs;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] acc_addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ready_in = 1'b0, pwr_asleep = 1'b0, irq_pend = 1'b0, irq_en = 1'b0;
    logic [5:0] map_index;
    logic       level_irq, soft_rst_req, pwr_down_req, io8_flag, drive_num, stschg_n;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       pend = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pccfg_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .ready_in(ready_in), .pwr_asleep(pwr_asleep), .irq_pend(irq_pend),
        .irq_en(irq_en), .map_index(map_index), .level_irq(level_irq),
        .soft_rst_req(soft_rst_req), .pwr_down_req(pwr_down_req),
        .io8_flag(io8_flag), .drive_num(drive_num), .stschg_n(stschg_n)
    );

    // monitor: compare read data the clock after the strobe
    always @(posedge clk) pend <= rd_en;
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (rd_data !== e) begin
                n_bad++;
                $display("FAIL %s: read got %02h expected %02h", t, rd_data, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        acc_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        acc_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
        n_vec++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", t, act, e);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(10'h200, 8'h00, "R1 option");
        rd(10'h202, 8'h00, "R1 status");
        rd(10'h204, 8'h0C, "R1 pin");
        rd(10'h206, 8'h00, "R1 socket");
        chk({2'b0, map_index}, 8'h00, "R1 index");
        chk({7'b0, stschg_n}, 8'h01, "R1 pin high");
        chk({7'b0, soft_rst_req}, 8'h00, "R1 srst");

        // R11 drive number
        wr(10'h206, 8'h10);
        chk({7'b0, drive_num}, 8'h01, "R11 drive set");
        rd(10'h206, 8'h10, "R11 readback");
        wr(10'h206, 8'hEF);
        rd(10'h206, 8'h00, "R11 other bits");

        // R2 option
        wr(10'h200, 8'h41);
        chk({2'b0, map_index}, 8'h01, "R2 index");
        chk({7'b0, level_irq}, 8'h01, "R2 level");
        rd(10'h200, 8'h41, "R2 readback");
        wr(10'h200, 8'h03);
        chk({7'b0, level_irq}, 8'h00, "R2 pulse");
        rd(10'h200, 8'h03, "R2 readback2");

        // R12 odd and unmapped addresses
        wr(10'h201, 8'hFF);
        wr(10'h207, 8'h10);
        wr(10'h208, 8'hFF);
        rd(10'h200, 8'h03, "R12 option kept");
        chk({7'b0, drive_num}, 8'h00, "R12 drive kept");
        rd(10'h201, 8'h00, "R12 odd read");
        rd(10'h205, 8'h00, "R12 odd read pin");
        rd(10'h208, 8'h00, "R12 unmapped read");

        // R3 soft reset
        wr(10'h200, 8'h85);
        chk({7'b0, soft_rst_req}, 8'h01, "R3 set");
        chk({2'b0, map_index}, 8'h00, "R3 index cleared");
        tick(5);
        chk({7'b0, soft_rst_req}, 8'h01, "R3 sticky");
        rd(10'h200, 8'h80, "R3 readback");
        wr(10'h200, 8'hC5);
        rd(10'h200, 8'hC0, "R3 index stays zero");
        wr(10'h200, 8'h02);
        chk({7'b0, soft_rst_req}, 8'h00, "R3 cleared");
        chk({2'b0, map_index}, 8'h02, "R3 index after clear");

        // R4 status writable bits
        wr(10'h202, 8'h60);
        rd(10'h202, 8'h60, "R4 readback");
        chk({7'b0, io8_flag}, 8'h01, "R4 io8");
        wr(10'h202, 8'h79);
        rd(10'h202, 8'h60, "R4 fixed zeros");

        // R5 interrupt
        irq_pend = 1'b1; tick(1);
        rd(10'h202, 8'h60, "R5 disabled");
        irq_en = 1'b1; tick(1);
        rd(10'h202, 8'h62, "R5 enabled");
        irq_pend = 1'b0; tick(1);
        rd(10'h202, 8'h60, "R5 serviced");

        // R7, R9, R10 ready change
        ready_in = 1'b1; tick(1);
        rd(10'h204, 8'h2E, "R7 flag and ready");
        rd(10'h202, 8'hE0, "R9 chged");
        chk({7'b0, stschg_n}, 8'h00, "R10 pin low");

        // R8 mask
        wr(10'h204, 8'h00);
        rd(10'h204, 8'h2E, "R8 unmasked keeps flag");
        wr(10'h204, 8'h02);
        rd(10'h204, 8'h0E, "R8 masked clears flag");
        chk({7'b0, stschg_n}, 8'h01, "R10 pin high no flag");

        // R10 gating conditions
        ready_in = 1'b0; tick(1);
        rd(10'h204, 8'h2C, "R7 falling edge flag");
        chk({7'b0, stschg_n}, 8'h00, "R10 pin low again");
        wr(10'h202, 8'h20);
        chk({7'b0, stschg_n}, 8'h01, "R10 enable off");
        wr(10'h202, 8'h60);
        chk({7'b0, stschg_n}, 8'h00, "R10 enable on");
        wr(10'h200, 8'h00);
        chk({7'b0, stschg_n}, 8'h01, "R10 memory mode");
        wr(10'h204, 8'h02);
        wr(10'h200, 8'h01);

        // R6 power transitions
        ready_in = 1'b1; tick(2);
        wr(10'h204, 8'h02);
        rd(10'h204, 8'h0E, "R6 prep");
        wr(10'h202, 8'h64);
        tick(2);
        chk({7'b0, pwr_down_req}, 8'h01, "R6 pwd req");
        rd(10'h204, 8'h2C, "R6 busy going down");
        rd(10'h202, 8'hE4, "R6 status");
        tick(3);
        rd(10'h204, 8'h2C, "R6 still busy");
        pwr_asleep = 1'b1; tick(2);
        rd(10'h204, 8'h2E, "R6 asleep ready");
        wr(10'h202, 8'h60);
        tick(1);
        rd(10'h204, 8'h2C, "R6 busy waking");
        pwr_asleep = 1'b0; tick(2);
        rd(10'h204, 8'h2E, "R6 awake ready");
        chk({7'b0, pwr_down_req}, 8'h00, "R6 pwd off");

        // R3 hard reset clears soft reset request
        wr(10'h200, 8'h80);
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(1);
        chk({7'b0, soft_rst_req}, 8'h00, "R3 hard reset clears");
        rd(10'h200, 8'h00, "R3 option after hard reset");

        tick(3);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule